// File: doc/BRIEF.md
# Parallel Port Line-Change Event Codec

This block turns activity on a parallel printer port into a compact stream of change events and turns such a stream back into line levels. On the host side it cleans the incoming data and control lines with a per-bit glitch filter, compares the filtered levels with the last levels it reported, and pushes an event word into a FIFO whenever they differ. A serial link then drains the FIFO through a simple valid/pop port. On the target side the same FIFO is filled from the link, and a decoder drains it one event per cycle and drives the port lines to the levels carried by each event.

One FIFO serves both roles. The `role_tgt_i` input selects the role. When it is low, the encoder fills the FIFO and the link port drains it. When it is high, the link port fills the FIFO and the decoder drains it. Only transitions travel across the link, so an idle port costs no bandwidth.

Top module: `pport_event_codec`

## Requirements
- R1: In host role, each accepted change of the filtered lines produces exactly one event per changed line group, and lines that stay steady produce none. A change held steadily becomes visible on `link_vld_o` FILT_N+1 rising edges after the inputs change.
- R2: An event word is DATA_W+1 bits wide. Bit DATA_W is the kind: 1 for control, 0 for data. A data event carries the data lines in bits DATA_W-1:0. A control event carries the control lines in bits CTRL_W-1:0, and all its other payload bits are zero.
- R3: When data and control lines are accepted on the same cycle, the control event enters the FIFO one cycle before the data event.
- R4: A line level that lasts fewer than FILT_N consecutive clock samples produces no event. A level that lasts FILT_N samples is accepted.
- R5: When the FIFO is full, a new event is dropped, and the entries already queued stay intact and in order.
- R6: Every dropped event raises `ovf_o` for exactly one cycle, on the cycle after the drop.
- R7: In host role, `link_vld_o` shows that the FIFO is not empty, `link_evt_o` shows the oldest entry, and `link_rd_i` removes one entry. `link_wr_i` has no effect in host role.
- R8: In target role, `link_wr_i` queues `link_evt_i`, and the decoder pops one entry per cycle on its own. The line outputs change on the second rising edge after the write edge, which is one clock after the pop, and they hold between events. `link_vld_o` stays low.
- R9: A control event updates only `line_ctrl_o`, taken from its low CTRL_W bits, with the padding bits ignored. A data event updates only `line_data_o`.
- R10: After reset, `line_data_o`, `line_ctrl_o`, `link_vld_o` and `ovf_o` are all zero, and the recorded line state is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_tgt_i | input | 1 | 0 = host role (encode), 1 = target role (decode) |
| line_data_i | input | DATA_W | Raw parallel data lines |
| line_ctrl_i | input | CTRL_W | Raw parallel control lines |
| line_data_o | output | DATA_W | Replayed data lines |
| line_ctrl_o | output | CTRL_W | Replayed control lines |
| link_evt_o | output | DATA_W+1 | Oldest queued event (host role) |
| link_vld_o | output | 1 | A queued event is available (host role) |
| link_rd_i | input | 1 | Removes the oldest event (host role) |
| link_evt_i | input | DATA_W+1 | Event arriving from the link (target role) |
| link_wr_i | input | 1 | Queues `link_evt_i` (target role) |
| ovf_o | output | 1 | One-cycle pulse for each dropped event |

## Verification
The assertions check several rules on every cycle. The filter may only switch a bit to the level that was sampled on the previous cycle. A full FIFO that is not being read stays full. An encoder attempt against a full FIFO is always followed by an overflow pulse. The replayed lines move only two cycles after a decoder pop. Every control event has zero padding bits. Other behaviours need the bench's scenarios. These are the exact event contents and their order, control before data when both change together, the suppression of short spikes, which entries survive an overflow, and the precise edge on which a target-side write reaches the lines.

// File: rtl/pport_codec_pkg.sv
package pport_codec_pkg;
   // Kind flag carried in the top bit of every event word
   typedef enum logic {
      EVK_DATA = 1'b0,
      EVK_CTRL = 1'b1
   } evt_kind_e;
endpackage

// File: rtl/pport_glitch_filter.sv
module pport_glitch_filter #(
   parameter int W = 8,
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] filt_o
);
   localparam int CW = (N > 1) ? $clog2(N) : 1;
   localparam logic [CW-1:0] LAST = CW'(N - 1);

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (N == 1) begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt_o[b] <= 1'b0;
            else        filt_o[b] <= raw_i[b];
         end
      end else begin : g_count
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_o[b] <= 1'b0;
               run_q     <= '0;
            end else if (raw_i[b] == filt_o[b]) begin
               run_q <= '0;
            end else if (run_q == LAST) begin
               filt_o[b] <= raw_i[b];
               run_q     <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pport_event_fifo.sv
module pport_event_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full
);
   localparam int PW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [PW:0]   cnt_q;
   logic          do_wr, do_rd;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == (PW+1)'(DEPTH));
   assign do_wr   = wr_en && !full;
   assign do_rd   = rd_en && !empty;
   assign rd_data = mem[rp_q];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_wr) wp_q <= wp_q + 1'b1;
         if (do_rd) rp_q <= rp_q + 1'b1;
         cnt_q <= cnt_q + {{PW{1'b0}}, do_wr} - {{PW{1'b0}}, do_rd};
      end
   end
endmodule

// File: rtl/pport_change_encoder.sv
module pport_change_encoder
   import pport_codec_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CTRL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic              full_i,
   output logic              attempt_o,
   output logic              push_o,
   output logic [DATA_W:0]   word_o,
   output logic              ovf_o
);
   logic [DATA_W-1:0] rec_data_q;
   logic [CTRL_W-1:0] rec_ctrl_q;
   logic              ctrl_chg, data_chg;

   assign ctrl_chg  = (ctrl_i != rec_ctrl_q);
   assign data_chg  = (data_i != rec_data_q);
   assign attempt_o = en_i && (ctrl_chg || data_chg);
   assign push_o    = attempt_o && !full_i;

   // Control changes win; a pending data change goes out on a later cycle
   always_comb begin
      word_o = '0;
      if (ctrl_chg) begin
         word_o[DATA_W]       = EVK_CTRL;
         word_o[CTRL_W-1:0]   = ctrl_i;
      end else begin
         word_o[DATA_W]       = EVK_DATA;
         word_o[DATA_W-1:0]   = data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_data_q <= '0;
         rec_ctrl_q <= '0;
         ovf_o      <= 1'b0;
      end else begin
         ovf_o <= attempt_o && full_i;
         if (!en_i) begin
            rec_data_q <= data_i;
            rec_ctrl_q <= ctrl_i;
         end else if (ctrl_chg) begin
            rec_ctrl_q <= ctrl_i;
         end else if (data_chg) begin
            rec_data_q <= data_i;
         end
      end
   end
endmodule

// File: rtl/pport_line_decoder.sv
module pport_line_decoder
   import pport_codec_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CTRL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pop_i,
   input  logic [DATA_W:0]   word_i,
   output logic [DATA_W-1:0] data_o,
   output logic [CTRL_W-1:0] ctrl_o
);
   logic            pend_q;
   logic [DATA_W:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         word_q <= '0;
         data_o <= '0;
         ctrl_o <= '0;
      end else begin
         pend_q <= pop_i;
         if (pop_i) word_q <= word_i;
         if (pend_q) begin
            if (evt_kind_e'(word_q[DATA_W]) == EVK_CTRL) ctrl_o <= word_q[CTRL_W-1:0];
            else                                         data_o <= word_q[DATA_W-1:0];
         end
      end
   end
endmodule

// File: rtl/pport_event_codec.sv
module pport_event_codec #(
   parameter int DATA_W     = 8,
   parameter int CTRL_W     = 4,
   parameter int FILT_N     = 4,
   parameter int FIFO_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              role_tgt_i,
   input  logic [DATA_W-1:0] line_data_i,
   input  logic [CTRL_W-1:0] line_ctrl_i,
   output logic [DATA_W-1:0] line_data_o,
   output logic [CTRL_W-1:0] line_ctrl_o,
   output logic [DATA_W:0]   link_evt_o,
   output logic              link_vld_o,
   input  logic              link_rd_i,
   input  logic [DATA_W:0]   link_evt_i,
   input  logic              link_wr_i,
   output logic              ovf_o
);
   localparam int EVT_W = DATA_W + 1;

   if (CTRL_W < 1 || CTRL_W > DATA_W) begin : g_bad_ctrl_w
      $error("CTRL_W must lie in 1..DATA_W");
   end
   if (FILT_N < 1) begin : g_bad_filt_n
      $error("FILT_N must be at least 1");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] filt_data;
   logic [CTRL_W-1:0] filt_ctrl;
   logic              enc_attempt, enc_push, enc_ovf;
   logic [EVT_W-1:0]  enc_word;
   logic              fifo_wr, fifo_rd, fifo_empty, fifo_full;
   logic [EVT_W-1:0]  fifo_wdata, fifo_rdata;
   logic              dec_pop, lnk_ovf_q;

   pport_glitch_filter #(.W(DATA_W), .N(FILT_N)) i_filt_data (
      .clk(clk), .rst_n(rst_n), .raw_i(line_data_i), .filt_o(filt_data)
   );
   pport_glitch_filter #(.W(CTRL_W), .N(FILT_N)) i_filt_ctrl (
      .clk(clk), .rst_n(rst_n), .raw_i(line_ctrl_i), .filt_o(filt_ctrl)
   );

   pport_change_encoder #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_enc (
      .clk(clk), .rst_n(rst_n), .en_i(!role_tgt_i),
      .data_i(filt_data), .ctrl_i(filt_ctrl), .full_i(fifo_full),
      .attempt_o(enc_attempt), .push_o(enc_push), .word_o(enc_word), .ovf_o(enc_ovf)
   );

   // Shared queue: the role picks which side writes and which side reads
   assign fifo_wr    = role_tgt_i ? (link_wr_i && !fifo_full) : enc_push;
   assign fifo_wdata = role_tgt_i ? link_evt_i : enc_word;
   assign dec_pop    = role_tgt_i && !fifo_empty;
   assign fifo_rd    = role_tgt_i ? dec_pop : (link_rd_i && !fifo_empty);

   pport_event_fifo #(.W(EVT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fifo_wr), .wr_data(fifo_wdata),
      .rd_en(fifo_rd), .rd_data(fifo_rdata),
      .empty(fifo_empty), .full(fifo_full)
   );

   pport_line_decoder #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_dec (
      .clk(clk), .rst_n(rst_n), .pop_i(dec_pop), .word_i(fifo_rdata),
      .data_o(line_data_o), .ctrl_o(line_ctrl_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lnk_ovf_q <= 1'b0;
      else        lnk_ovf_q <= role_tgt_i && link_wr_i && fifo_full;
   end

   assign link_evt_o = fifo_rdata;
   assign link_vld_o = !role_tgt_i && !fifo_empty;
   assign ovf_o      = enc_ovf || lnk_ovf_q;
endmodule

// File: rtl/pport_event_codec_chk.sv
module pport_event_codec_chk #(
   parameter int DATA_W = 8,
   parameter int CTRL_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] line_data_i,
   input logic [DATA_W-1:0] filt_data,
   input logic              link_vld_o,
   input logic [DATA_W:0]   link_evt_o,
   input logic              fifo_full,
   input logic              fifo_rd,
   input logic              enc_attempt,
   input logic              ovf_o,
   input logic              dec_pop,
   input logic [DATA_W-1:0] line_data_o,
   input logic [CTRL_W-1:0] line_ctrl_o
);
   // R4: a filtered bit may only move to the raw level seen on the prior sample
   a_r4_filter_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
      ((filt_data ^ $past(filt_data)) & ($past(line_data_i) ^ filt_data)) == '0);

   // R5: a full queue that nobody reads cannot accept anything
   a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !fifo_rd) |=> fifo_full);

   // R6: an encoder attempt against a full queue is flagged next cycle
   a_r6_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_attempt && fifo_full) |=> ovf_o);

   // R8: replayed lines move only two cycles after a decoder pop
   a_r8_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(dec_pop, 2) |-> ($stable(line_data_o) && $stable(line_ctrl_o)));

   // R2: control events carry zero padding above the control field
   a_r2_ctrl_padding: assert property (@(posedge clk) disable iff (!rst_n)
      (link_vld_o && link_evt_o[DATA_W]) |-> (link_evt_o[DATA_W-1:CTRL_W] == '0));
endmodule

bind pport_event_codec pport_event_codec_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .line_data_i(line_data_i), .filt_data(filt_data),
   .link_vld_o(link_vld_o), .link_evt_o(link_evt_o), .fifo_full(fifo_full),
   .fifo_rd(fifo_rd), .enc_attempt(enc_attempt), .ovf_o(ovf_o), .dec_pop(dec_pop),
   .line_data_o(line_data_o), .line_ctrl_o(line_ctrl_o)
);

// File: tb/test_pport_event_codec.sv
module test_pport_event_codec;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;

   // Stimulus and expected events, one row per step (control listed before data)
   localparam logic [7:0] V_D   [NVEC] = '{8'hA5, 8'hA5, 8'h3C, 8'h3C, 8'hFF, 8'h00};
   localparam logic [3:0] V_C   [NVEC] = '{4'h0, 4'h3, 4'h9, 4'h9, 4'h9, 4'h0};
   localparam int         V_N   [NVEC] = '{1, 1, 2, 0, 1, 2};
   localparam logic [8:0] V_E0  [NVEC] = '{9'h0A5, 9'h103, 9'h109, 9'h000, 9'h0FF, 9'h100};
   localparam logic [8:0] V_E1  [NVEC] = '{9'h000, 9'h000, 9'h03C, 9'h000, 9'h000, 9'h000};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       role_tgt_i = 1'b0;
   logic [7:0] line_data_i = '0;
   logic [3:0] line_ctrl_i = '0;
   logic [7:0] line_data_o;
   logic [3:0] line_ctrl_o;
   logic [8:0] link_evt_o;
   logic       link_vld_o;
   logic       link_rd_i = 1'b0;
   logic [8:0] link_evt_i = '0;
   logic       link_wr_i = 1'b0;
   logic       ovf_o;

   int n_cmp = 0;
   int n_bad = 0;
   int ovf_cnt = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pport_event_codec i_pport_event_codec (
      .clk(clk), .rst_n(rst_n), .role_tgt_i(role_tgt_i),
      .line_data_i(line_data_i), .line_ctrl_i(line_ctrl_i),
      .line_data_o(line_data_o), .line_ctrl_o(line_ctrl_o),
      .link_evt_o(link_evt_o), .link_vld_o(link_vld_o), .link_rd_i(link_rd_i),
      .link_evt_i(link_evt_i), .link_wr_i(link_wr_i), .ovf_o(ovf_o)
   );

   always @(negedge clk) if (rst_n && ovf_o === 1'b1) ovf_cnt++;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic pop_expect(string req, logic [8:0] exp);
      chk(req, 32'(link_vld_o), 32'd1);
      chk(req, 32'(link_evt_o), 32'(exp));
      link_rd_i = 1'b1;
      @(negedge clk);
      link_rd_i = 1'b0;
   endtask

   task automatic target_write(logic [8:0] w);
      link_evt_i = w;
      link_wr_i  = 1'b1;
      @(negedge clk);
      link_wr_i  = 1'b0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      idle(5);
      // R10: reset state
      chk("R10 data out", 32'(line_data_o), 32'h0);
      chk("R10 ctrl out", 32'(line_ctrl_o), 32'h0);
      chk("R10 vld", 32'(link_vld_o), 32'h0);
      chk("R10 ovf", 32'(ovf_o), 32'h0);
      rst_n = 1'b1;
      idle(3);
      chk("R10 no event from idle lines", 32'(link_vld_o), 32'h0);

      // R1, R2, R3: table of line patterns and their events
      for (int v = 0; v < NVEC; v++) begin
         line_data_i = V_D[v];
         line_ctrl_i = V_C[v];
         idle(8);
         if (V_N[v] > 0) pop_expect("R1 R2 first event", V_E0[v]);
         if (V_N[v] > 1) pop_expect("R3 control before data", V_E1[v]);
         chk("R1 no extra event", 32'(link_vld_o), 32'h0);
      end

      // R1, R4: latency of an accepted change is FILT_N+1 edges
      line_ctrl_i = 4'h2;
      idle(4);
      chk("R4 not yet visible after FILT_N edges", 32'(link_vld_o), 32'h0);
      idle(1);
      chk("R1 visible after FILT_N+1 edges", 32'(link_vld_o), 32'h1);
      pop_expect("R2 control event", 9'h102);

      // R4: a 3-sample spike is rejected
      line_data_i = 8'h01;
      idle(3);
      line_data_i = 8'h00;
      idle(8);
      chk("R4 spike makes no event", 32'(link_vld_o), 32'h0);

      // R5, R6: nine data events into an eight-entry queue
      ovf_cnt = 0;
      for (int i = 1; i <= 9; i++) begin
         line_data_i = 8'(i);
         idle(6);
      end
      idle(2);
      chk("R6 one overflow pulse", 32'(ovf_cnt), 32'd1);
      for (int i = 1; i <= 8; i++) pop_expect("R5 queued entries intact", 9'(i));
      chk("R5 dropped event absent", 32'(link_vld_o), 32'h0);

      // R7: link writes ignored in host role
      target_write(9'h1AA);
      idle(4);
      chk("R7 write ignored vld", 32'(link_vld_o), 32'h0);
      chk("R7 write ignored ctrl out", 32'(line_ctrl_o), 32'h0);

      // R8, R9: target role replay timing and field use
      role_tgt_i = 1'b1;
      idle(2);
      target_write(9'h10F);
      chk("R8 unchanged at write edge", 32'(line_ctrl_o), 32'h0);
      idle(1);
      chk("R8 unchanged at pop edge", 32'(line_ctrl_o), 32'h0);
      idle(1);
      chk("R8 updated one clock after pop", 32'(line_ctrl_o), 32'hF);
      chk("R9 data untouched by control event", 32'(line_data_o), 32'h0);
      chk("R8 vld low in target role", 32'(link_vld_o), 32'h0);

      target_write(9'h15A);
      idle(4);
      chk("R9 padding ignored", 32'(line_ctrl_o), 32'hA);
      target_write(9'h0C3);
      idle(4);
      chk("R9 data event", 32'(line_data_o), 32'hC3);
      chk("R9 control held", 32'(line_ctrl_o), 32'hA);

      target_write(9'h133);
      target_write(9'h07E);
      idle(5);
      chk("R8 back-to-back ctrl", 32'(line_ctrl_o), 32'h3);
      chk("R8 back-to-back data", 32'(line_data_o), 32'h7E);

      done = 1'b1;
      finish_run();
   end
endmodule